// File: doc/BRIEF.md
# Compacting Out-of-Order Issue Scheduler

This block holds renamed operations between the in-order rename stage and three execution pipes (add, multiply, store). Up to three operations enter per cycle in program order and join the tail of a 36-slot queue. Each operation has two source operands. Every source that is not yet ready carries a tag and waits until that tag appears on a bus it watches. Each source picks one of two bus groups when it enters: either the three result buses or the two load-operand buses. As a result, no source compares against more than three tags.

An operation is eligible to issue once both of its sources are ready. Each cycle, the block picks for each pipe that is not busy the eligible operation closest to the head of the queue. It presents that operation's identifier on the pipe's issue port in the same cycle. At the next clock edge the issued entries are removed and the survivors slide toward the head, keeping their order, so the occupied slots always form a contiguous prefix. Newly accepted operations are appended behind the survivors. The front end reads the free-slot count to decide how many operations it may send.

Top module: `oo_issue_sched`

## Requirements
- R1: After reset the queue is empty: `freeCount` is 36 and no `issValid` bit is set.
- R2: In a given cycle, pipe p raises `issValid[p]` only if two conditions hold: a queued operation whose pipe code is p has both sources ready, and `pipeBusy[p]` is low. The pipe codes are 0 for add, 1 for multiply and 2 for store. `issId` field p, bits [p*8 +: 8], carries that operation's identifier in the same cycle. At the next edge the issued operation leaves the queue.
- R3: When several eligible operations target the same pipe, the one closest to the head is issued. Age follows insertion order, and within one insertion group a lower slot index k counts as older.
- R4: In one cycle, up to three operations can issue, one per pipe, independently of each other.
- R5: A source whose load-select bit is 0 becomes ready from the cycle after a result bus b carries its tag with `resValid[b]` high, where the tag is in `resTag[b*7 +: 7]`. Load-bus traffic has no effect on such a source.
- R6: A source whose load-select bit is 1 becomes ready from the cycle after a load bus b carries its tag with `ldValid[b]` high, where the tag is in `ldTag[b*7 +: 7]`. Result-bus traffic has no effect on such a source.
- R7: A tag broadcast in the same cycle an operation is inserted is captured, so the operation can issue in the next cycle.
- R8: An insertion group is accepted whole only when its count of set `insValid` bits is no larger than `freeCount`. Otherwise none of its operations enter. For insertion slot k, the fields are:
  - pipe code at `insPipe[k*2 +: 2]`
  - identifier at `insId[k*8 +: 8]`
  - source s tag at `insSrcTag[(k*2+s)*7 +: 7]`
  - source s ready flag at `insSrcRdy[k*2+s]`
  - source s load-select bit at `insSrcLoad[k*2+s]`
- R9: Issued entries are removed by compaction. The remaining operations keep their relative age, and `freeCount` always equals 36 minus the number of queued operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 3 | Insertion slot valid bits |
| insPipe | input | 6 | Pipe code per insertion slot |
| insSrcTag | input | 42 | Source tags, two per insertion slot |
| insSrcRdy | input | 6 | Source already-ready flags |
| insSrcLoad | input | 6 | Source watches load buses (1) or result buses (0) |
| insId | input | 24 | Operation identifier per insertion slot |
| resValid | input | 3 | Result bus valid bits |
| resTag | input | 21 | Result bus tags |
| ldValid | input | 2 | Load bus valid bits |
| ldTag | input | 14 | Load bus tags |
| pipeBusy | input | 3 | Pipe cannot accept an operation this cycle |
| issValid | output | 3 | Issue strobe per pipe |
| issId | output | 24 | Identifier of the issued operation per pipe |
| freeCount | output | 6 | Number of free slots |

## Verification
The hardest situation to reach is a refused group: the queue must be nearly full when a larger group arrives, which ordinary traffic rarely causes. The stimulus produces it in two ways. A directed sequence holds every pipe busy while it fills the queue to exactly 36 and then offers one more operation. A random phase does the same with heavy insertion and mostly busy pipes. A narrow tag range, with bus traffic on both groups, makes wrong-group matches and same-cycle wakeups frequent.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int DEPTH  = 36;
  parameter int TAG_W  = 7;
  parameter int ID_W   = 8;
  parameter int INS_N  = 3;
  parameter int RES_N  = 3;
  parameter int LD_N   = 2;
  parameter int SRC_N  = 2;
  parameter int PIPE_N = 3;
  parameter int PIPE_W = 2;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef enum logic [PIPE_W-1:0] {
    PIPE_ADD = 2'd0, PIPE_MUL = 2'd1, PIPE_STORE = 2'd2, PIPE_NONE = 2'd3
  } pipe_e;

  typedef struct packed {
    logic                         valid;
    pipe_e                        pipe;
    logic [SRC_N-1:0]             rdy;
    logic [SRC_N-1:0]             useLd;
    logic [SRC_N-1:0][TAG_W-1:0]  tag;
    logic [ID_W-1:0]              id;
  } entry_t;

  typedef struct packed {
    logic                         accept;
    logic [PIPE_N-1:0]            pick;
    logic [PIPE_N-1:0][IDX_W-1:0] pickIdx;
  } strobe_t;

  function automatic entry_t wakeEntry(
    entry_t                      e,
    logic [RES_N-1:0]            rv,
    logic [RES_N-1:0][TAG_W-1:0] rt,
    logic [LD_N-1:0]             lv,
    logic [LD_N-1:0][TAG_W-1:0]  lt
  );
    entry_t w;
    w = e;
    for (int s = 0; s < SRC_N; s++) begin
      if (e.useLd[s]) begin
        for (int b = 0; b < LD_N; b++)
          if (lv[b] && lt[b] == e.tag[s]) w.rdy[s] = 1'b1;
      end else begin
        for (int b = 0; b < RES_N; b++)
          if (rv[b] && rt[b] == e.tag[s]) w.rdy[s] = 1'b1;
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEPTH-1:0] validVec,
  input  logic [DEPTH-1:0] readyVec,
  input  pipe_e            pipeVec [DEPTH],
  input  logic [INS_N-1:0] insValid,
  input  logic [PIPE_N-1:0] pipeBusy,
  output strobe_t          strobe,
  output logic [CNT_W-1:0] freeCount
);
  logic [CNT_W-1:0] occ, occNext, nIss, nAdd;
  logic [DEPTH-1:0] occMask;
  int               nIns;

  // oldest eligible entry per pipe: scan from tail so the head wins
  always_comb begin
    for (int p = 0; p < PIPE_N; p++) begin
      logic             found;
      logic [IDX_W-1:0] idx;
      found = 1'b0;
      idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (validVec[i] && readyVec[i] && pipeVec[i] == pipe_e'(PIPE_W'(p))) begin
          found = 1'b1;
          idx   = IDX_W'(i);
        end
      end
      strobe.pick[p]    = found && !pipeBusy[p];
      strobe.pickIdx[p] = idx;
    end
  end

  always_comb begin
    nIns          = $countones(insValid);
    strobe.accept = nIns <= (DEPTH - int'(occ));
    nIss          = CNT_W'($countones(strobe.pick));
    nAdd          = strobe.accept ? CNT_W'(nIns) : '0;
    occNext       = occ - nIss + nAdd;
    for (int i = 0; i < DEPTH; i++) occMask[i] = (i < int'(occ));
  end

  always_ff @(posedge clk) begin
    if (!rstN) occ <= '0;
    else       occ <= occNext;
  end

  assign freeCount = CNT_W'(DEPTH) - occ;

  // R9: storage holds exactly a contiguous prefix of occ entries
  a_r9_compact_prefix: assert property (@(posedge clk) disable iff (!rstN)
    validVec == occMask);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    int'(occ) <= DEPTH);
  // R8: a refused group adds nothing
  a_r8_group_refused: assert property (@(posedge clk) disable iff (!rstN)
    (|insValid && !strobe.accept) |=> occ == $past(occ) - $past(nIss));

  for (genvar p = 0; p < PIPE_N; p++) begin : g_busy
    // R2: a busy pipe never receives an operation
    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
      pipeBusy[p] |-> !strobe.pick[p]);
  end
endmodule

// File: rtl/sched_data.sv
module sched_data
  import sched_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobe,
  input  entry_t                      insEnt [INS_N],
  input  logic [RES_N-1:0]            resValid,
  input  logic [RES_N-1:0][TAG_W-1:0] resTag,
  input  logic [LD_N-1:0]             ldValid,
  input  logic [LD_N-1:0][TAG_W-1:0]  ldTag,
  output logic [DEPTH-1:0]            validVec,
  output logic [DEPTH-1:0]            readyVec,
  output pipe_e                       pipeVec [DEPTH],
  output logic [PIPE_N-1:0]           issValid,
  output logic [PIPE_N-1:0][ID_W-1:0] issId
);
  entry_t ents [DEPTH];
  entry_t nxt  [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      validVec[i] = ents[i].valid;
      readyVec[i] = &ents[i].rdy;
      pipeVec[i]  = ents[i].pipe;
    end
    for (int p = 0; p < PIPE_N; p++) begin
      issValid[p] = strobe.pick[p];
      issId[p]    = ents[strobe.pickIdx[p]].id;
    end
  end

  // compaction of survivors, then insertion behind them; all wake on the buses
  always_comb begin
    int  shift;
    int  off;
    logic gone;
    for (int i = 0; i < DEPTH; i++) nxt[i] = '0;
    shift = 0;
    for (int i = 0; i < DEPTH; i++) begin
      gone = 1'b0;
      for (int p = 0; p < PIPE_N; p++)
        if (strobe.pick[p] && int'(strobe.pickIdx[p]) == i) gone = 1'b1;
      if (ents[i].valid) begin
        if (gone) shift++;
        else nxt[IDX_W'(i - shift)] = wakeEntry(ents[i], resValid, resTag, ldValid, ldTag);
      end
    end
    off = 0;
    for (int i = 0; i < DEPTH; i++) if (ents[i].valid) off++;
    off = off - shift;
    if (strobe.accept) begin
      for (int k = 0; k < INS_N; k++) begin
        if (insEnt[k].valid) begin
          if (off < DEPTH)
            nxt[IDX_W'(off)] = wakeEntry(insEnt[k], resValid, resTag, ldValid, ldTag);
          off++;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
    end else begin
      ents <= nxt;
    end
  end

  for (genvar p = 0; p < PIPE_N; p++) begin : g_chk
    // R2: the chosen slot holds a ready operation for this pipe
    a_r2_pick_ready: assert property (@(posedge clk) disable iff (!rstN)
      strobe.pick[p] |-> (ents[strobe.pickIdx[p]].valid && (&ents[strobe.pickIdx[p]].rdy)
                          && ents[strobe.pickIdx[p]].pipe == pipe_e'(PIPE_W'(p))));
  end
endmodule

// File: rtl/oo_issue_sched.sv
module oo_issue_sched
  import sched_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [INS_N-1:0]            insValid,
  input  logic [INS_N*PIPE_W-1:0]     insPipe,
  input  logic [INS_N*SRC_N*TAG_W-1:0] insSrcTag,
  input  logic [INS_N*SRC_N-1:0]      insSrcRdy,
  input  logic [INS_N*SRC_N-1:0]      insSrcLoad,
  input  logic [INS_N*ID_W-1:0]       insId,
  input  logic [RES_N-1:0]            resValid,
  input  logic [RES_N*TAG_W-1:0]      resTag,
  input  logic [LD_N-1:0]             ldValid,
  input  logic [LD_N*TAG_W-1:0]       ldTag,
  input  logic [PIPE_N-1:0]           pipeBusy,
  output logic [PIPE_N-1:0]           issValid,
  output logic [PIPE_N*ID_W-1:0]      issId,
  output logic [CNT_W-1:0]            freeCount
);
  entry_t                      insEnt [INS_N];
  logic [RES_N-1:0][TAG_W-1:0] resTagA;
  logic [LD_N-1:0][TAG_W-1:0]  ldTagA;
  logic [DEPTH-1:0]            validVec, readyVec;
  pipe_e                       pipeVec [DEPTH];
  strobe_t                     strobe;
  logic [PIPE_N-1:0][ID_W-1:0] issIdA;

  always_comb begin
    for (int k = 0; k < INS_N; k++) begin
      insEnt[k].valid = insValid[k];
      insEnt[k].pipe  = pipe_e'(insPipe[k*PIPE_W +: PIPE_W]);
      insEnt[k].id    = insId[k*ID_W +: ID_W];
      for (int s = 0; s < SRC_N; s++) begin
        insEnt[k].rdy[s]   = insSrcRdy[k*SRC_N + s];
        insEnt[k].useLd[s] = insSrcLoad[k*SRC_N + s];
        insEnt[k].tag[s]   = insSrcTag[(k*SRC_N + s)*TAG_W +: TAG_W];
      end
    end
    for (int b = 0; b < RES_N; b++) resTagA[b] = resTag[b*TAG_W +: TAG_W];
    for (int b = 0; b < LD_N; b++)  ldTagA[b]  = ldTag[b*TAG_W +: TAG_W];
  end

  sched_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .validVec(validVec), .readyVec(readyVec),
    .pipeVec(pipeVec), .insValid(insValid), .pipeBusy(pipeBusy),
    .strobe(strobe), .freeCount(freeCount)
  );

  sched_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .insEnt(insEnt),
    .resValid(resValid), .resTag(resTagA), .ldValid(ldValid), .ldTag(ldTagA),
    .validVec(validVec), .readyVec(readyVec), .pipeVec(pipeVec),
    .issValid(issValid), .issId(issIdA)
  );

  assign issId = issIdA;
endmodule

// File: tb/oo_issue_sched_test.sv
module oo_issue_sched_test;
  import sched_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [INS_N-1:0]             insValid;
  logic [INS_N*PIPE_W-1:0]      insPipe;
  logic [INS_N*SRC_N*TAG_W-1:0] insSrcTag;
  logic [INS_N*SRC_N-1:0]       insSrcRdy, insSrcLoad;
  logic [INS_N*ID_W-1:0]        insId;
  logic [RES_N-1:0]             resValid;
  logic [RES_N*TAG_W-1:0]       resTag;
  logic [LD_N-1:0]              ldValid;
  logic [LD_N*TAG_W-1:0]        ldTag;
  logic [PIPE_N-1:0]            pipeBusy;
  logic [PIPE_N-1:0]            issValid;
  logic [PIPE_N*ID_W-1:0]       issId;
  logic [CNT_W-1:0]             freeCount;

  oo_issue_sched uut (.*);

  typedef struct {
    int pipe; bit rdy[SRC_N]; bit ld[SRC_N]; int tag[SRC_N]; int id;
  } mop_t;

  mop_t model[$];
  mop_t bIns[INS_N];
  bit   bInsV[INS_N];
  bit   bResV[RES_N]; int bResT[RES_N];
  bit   bLdV[LD_N];   int bLdT[LD_N];
  bit   bBusy[PIPE_N];
  int   tests = 0, fails = 0, nextId = 1;
  bit   done = 1'b0;

  always_comb begin
    for (int k = 0; k < INS_N; k++) begin
      insValid[k] = bInsV[k];
      insPipe[k*PIPE_W +: PIPE_W] = PIPE_W'(bIns[k].pipe);
      insId[k*ID_W +: ID_W] = ID_W'(bIns[k].id);
      for (int s = 0; s < SRC_N; s++) begin
        insSrcTag[(k*SRC_N+s)*TAG_W +: TAG_W] = TAG_W'(bIns[k].tag[s]);
        insSrcRdy[k*SRC_N+s]  = bIns[k].rdy[s];
        insSrcLoad[k*SRC_N+s] = bIns[k].ld[s];
      end
    end
    for (int b = 0; b < RES_N; b++) begin resValid[b] = bResV[b]; resTag[b*TAG_W +: TAG_W] = TAG_W'(bResT[b]); end
    for (int b = 0; b < LD_N; b++)  begin ldValid[b] = bLdV[b];   ldTag[b*TAG_W +: TAG_W] = TAG_W'(bLdT[b]); end
    for (int p = 0; p < PIPE_N; p++) pipeBusy[p] = bBusy[p];
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic mop_t wakeM(mop_t o);
    mop_t w = o;
    for (int s = 0; s < SRC_N; s++) begin
      if (o.ld[s]) begin
        for (int b = 0; b < LD_N; b++) if (bLdV[b] && bLdT[b] == o.tag[s]) w.rdy[s] = 1;
      end else begin
        for (int b = 0; b < RES_N; b++) if (bResV[b] && bResT[b] == o.tag[s]) w.rdy[s] = 1;
      end
    end
    return w;
  endfunction

  task automatic idle();
    for (int k = 0; k < INS_N; k++) bInsV[k] = 0;
    for (int b = 0; b < RES_N; b++) bResV[b] = 0;
    for (int b = 0; b < LD_N; b++)  bLdV[b] = 0;
    for (int p = 0; p < PIPE_N; p++) bBusy[p] = 0;
  endtask

  function automatic mop_t mkOp(int pipe, bit r0, bit l0, int t0, bit r1, bit l1, int t1);
    mop_t o;
    o.pipe = pipe; o.rdy[0] = r0; o.ld[0] = l0; o.tag[0] = t0;
    o.rdy[1] = r1; o.ld[1] = l1; o.tag[1] = t1;
    o.id = nextId & 8'hff;
    return o;
  endfunction

  task automatic putOp(int k, mop_t o);
    bIns[k] = o; bInsV[k] = 1; nextId++;
  endtask

  // called just after a falling edge with inputs applied
  task automatic step(string req);
    int  expIdx[PIPE_N];
    bit  expV[PIPE_N];
    int  nIns;
    mop_t nq[$];
    #1;
    for (int p = 0; p < PIPE_N; p++) begin
      expV[p] = 0; expIdx[p] = -1;
      if (!bBusy[p])
        for (int i = 0; i < model.size(); i++)
          if (!expV[p] && model[i].pipe == p && model[i].rdy[0] && model[i].rdy[1]) begin
            expV[p] = 1; expIdx[p] = i;
          end
      check(issValid[p] == expV[p], req, $sformatf("issValid[%0d]", p), int'(issValid[p]), int'(expV[p]));
      if (expV[p] && issValid[p])
        check(int'(issId[p*ID_W +: ID_W]) == model[expIdx[p]].id, req,
              $sformatf("issId[%0d]", p), int'(issId[p*ID_W +: ID_W]), model[expIdx[p]].id);
    end
    check(int'(freeCount) == DEPTH - model.size(), req, "freeCount",
          int'(freeCount), DEPTH - model.size());
    nIns = 0;
    for (int k = 0; k < INS_N; k++) nIns += int'(bInsV[k]);
    for (int i = 0; i < model.size(); i++)
      if (i != expIdx[0] && i != expIdx[1] && i != expIdx[2]) nq.push_back(wakeM(model[i]));
    if (nIns <= DEPTH - model.size())
      for (int k = 0; k < INS_N; k++) if (bInsV[k]) nq.push_back(wakeM(bIns[k]));
    model = nq;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle();
    for (int k = 0; k < INS_N; k++) bIns[k] = mkOp(0, 1, 0, 0, 1, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(int'(freeCount) == DEPTH, "R1", "freeCount", int'(freeCount), DEPTH);
    check(issValid == '0, "R1", "issValid", int'(issValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: wakeup in the insertion cycle
    idle(); putOp(0, mkOp(0, 0, 0, 9, 1, 0, 0)); bResV[1] = 1; bResT[1] = 9;
    step("R7");
    idle(); step("R7");
    idle(); step("R7");

    // R5 R6: each source ignores the other bus group
    idle(); putOp(0, mkOp(1, 0, 0, 5, 0, 1, 6)); step("R5");
    idle(); bLdV[0] = 1; bLdT[0] = 5; bResV[2] = 1; bResT[2] = 6; step("R6");
    idle(); step("R6");
    idle(); bResV[0] = 1; bResT[0] = 5; bLdV[1] = 1; bLdT[1] = 6; step("R5");
    idle(); step("R5");
    idle(); step("R5");

    // R3: three ready adds, oldest first; R4: all pipes together
    idle(); for (int k = 0; k < 3; k++) putOp(k, mkOp(0, 1, 0, 0, 1, 0, 0)); step("R3");
    idle(); putOp(0, mkOp(1, 1, 0, 0, 1, 0, 0)); putOp(2, mkOp(2, 1, 0, 0, 1, 0, 0)); step("R4");
    idle(); step("R4");
    idle(); step("R3");
    idle(); step("R3");

    // R8: fill to 36 with all pipes busy, then offer more
    for (int c = 0; c < 12; c++) begin
      idle(); bBusy[0] = 1; bBusy[1] = 1; bBusy[2] = 1;
      for (int k = 0; k < 3; k++) putOp(k, mkOp(k, 1, 0, 0, 1, 0, 0));
      step("R8");
    end
    idle(); bBusy[0] = 1; bBusy[1] = 1; bBusy[2] = 1; putOp(1, mkOp(0, 1, 0, 0, 1, 0, 0)); step("R8");
    idle(); bBusy[0] = 1; bBusy[1] = 1; bBusy[2] = 1; step("R8");
    // R9: drain, order kept through compaction
    for (int c = 0; c < 14; c++) begin idle(); bBusy[c % 3] = (c % 4 == 0); step("R9"); end

    // random: R2 R3 R4 R9 against the reference queue
    void'($urandom(32'h5eed_1234));
    for (int phase = 0; phase < 4; phase++) begin
      for (int c = 0; c < 1000; c++) begin
        int insPct = (phase == 1) ? 90 : 50;
        int busyPct = (phase == 1) ? 80 : (phase == 3 ? 5 : 30);
        idle();
        for (int k = 0; k < INS_N; k++)
          if (($urandom % 100) < insPct)
            putOp(k, mkOp($urandom % 3, $urandom % 2, $urandom % 2, $urandom % 16,
                          $urandom % 2, $urandom % 2, $urandom % 16));
        for (int b = 0; b < RES_N; b++) begin bResV[b] = $urandom % 2; bResT[b] = $urandom % 16; end
        for (int b = 0; b < LD_N; b++)  begin bLdV[b] = $urandom % 2;  bLdT[b] = $urandom % 16; end
        for (int p = 0; p < PIPE_N; p++) bBusy[p] = (($urandom % 100) < busyPct);
        step("R2 R3 R4 R8 R9");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule